// File: doc/BRIEF.md
# Combinator Graph Rewrite Unit

This unit runs the rewrite rules of a few non-strict combinators over a binary program graph kept in heap memory. Each heap node has a left cell and a right cell, and each cell holds a node index. When the threading engine has unwound the left spine of the graph and found a combinator, it hands that combinator's code to this unit through a go/ready handshake. The spine stack then holds the visited nodes, with depth 0 on top. In the text below, Rn means the right cell of the node held at spine depth n.

The unit handles three combinators. The identity (I) and the constant (K) are projections: they load the next interpretive pointer from R0, pop one or two spine entries and write nothing to the heap. The S' rule takes three fresh nodes from a bump-pointer allocator and builds `(c (f x)) (g x)` from the four arguments c=R0, f=R1, g=R2, x=R3. It then rewrites the subgraph root at depth 3, pops three entries and resumes threading at the new application node. The unit makes one heap access per cycle, and every argument read comes before the first heap write. If the heap has no room for three nodes, the unit stalls. An unknown code is reported as an error and changes nothing.

Top module: `crw_top`

## Requirements
- R1: Code 3'b001 (I) completes with `out_ip` equal to R0, a pop of 1 entry, `out_err` low and no heap write.
- R2: Code 3'b010 (K) completes with `out_ip` equal to R0, a pop of 2 entries, `out_err` low and no heap write.
- R3: Code 3'b100 (S') allocates three consecutive nodes temp0, temp1 and temp2, starting at the bump pointer. The pointer starts at parameter `ALLOC_BASE` and advances by 3 with each S'.
- R4: S' writes temp0 = (R1, R3), temp1 = (R0, temp0) and temp2 = (R2, R3), given as (left, right). Left is `heap_side`=0 and right is `heap_side`=1.
- R5: S' writes the node at spine depth 3 with temp1 in its left cell and temp2 in its right cell.
- R6: S' completes with `out_ip` equal to temp1, a pop of 3 entries and `out_err` low.
- R7: S' leaves the argument nodes at spine depths 0, 1 and 2 unchanged in the heap.
- R8: `heap_re` and `heap_we` are never high together. Within one operation, no read follows a write. S' makes exactly 8 heap writes.
- R9: If an S' arrives when fewer than three nodes remain below `ALLOC_LIMIT`, `heap_full` rises and stays high. The unit then writes nothing, pops nothing, signals no completion and keeps `ready` low.
- R10: Any other code completes with `out_err` high, `out_ip` 0, no pop and no heap access.
- R11: After reset, `ready` is high and `heap_full` and `out_valid` are low. `out_valid` is a one-cycle pulse, and `ready` is low from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Dispatch request, accepted when `ready` is high |
| op | input | 3 | Combinator code |
| ready | output | 1 | Unit is idle and can accept a dispatch |
| spine_sel | output | 2 | Spine depth being addressed (0 = top) |
| spine_node | input | AW | Node index stored at depth `spine_sel` |
| spine_pop | output | 1 | Pop request, valid with `out_valid` |
| spine_pop_n | output | 2 | Number of entries to pop |
| heap_re | output | 1 | Heap read strobe (data returns one cycle later) |
| heap_we | output | 1 | Heap write strobe |
| heap_node | output | AW | Heap node index |
| heap_side | output | 1 | Cell select: 0 left, 1 right |
| heap_wdata | output | AW | Cell write data |
| heap_rdata | input | AW | Cell read data |
| out_valid | output | 1 | Completion pulse |
| out_ip | output | AW | Next interpretive pointer |
| out_err | output | 1 | Unsupported code |
| heap_full | output | 1 | Allocator exhausted, unit stalled |

## Verification
Each projection is dispatched over graphs whose R0 values differ, including the top node index. A pointer reloaded from the wrong cell or depth shows up in `out_ip`, and a wrong pop count shows up in the stack model. S' is run on two graphs with different argument values. This shows that each new cell takes the argument from the correct depth, that the allocator returns consecutive temps, and that the argument nodes stay untouched. Two undefined codes, followed by an S' that overruns the allocation limit, show the error path and the stall path, and both must leave the heap and stack as they were.

// File: rtl/crw_pkg.sv
package crw_pkg;

  localparam logic [2:0] OP_IDENT = 3'b001;
  localparam logic [2:0] OP_CONST = 3'b010;
  localparam logic [2:0] OP_SPRM  = 3'b100;

  localparam logic SIDE_L = 1'b0;
  localparam logic SIDE_R = 1'b1;

  localparam int SPRM_NEW   = 3;
  localparam int SPRM_READS = 4;
  localparam int SPRM_WRITES = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_WRITE, ST_FIN, ST_FULL
  } crw_state_e;

  function automatic logic [1:0] pops_for(input logic [2:0] code);
    case (code)
      OP_IDENT: pops_for = 2'd1;
      OP_CONST: pops_for = 2'd2;
      OP_SPRM:  pops_for = 2'd3;
      default:  pops_for = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] last_read(input logic [2:0] code);
    last_read = (code == OP_SPRM) ? 2'(SPRM_READS - 1) : 2'd0;
  endfunction

  function automatic logic room_for(input int ptr, input int need, input int limit);
    room_for = (ptr + need) <= limit;
  endfunction

endpackage

// File: rtl/crw_alloc.sv
module crw_alloc #(
  parameter int AW          = 8,
  parameter int ALLOC_BASE  = 16,
  parameter int ALLOC_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic [AW-1:0] base_o,
  output logic          room_o
);
  import crw_pkg::*;

  logic [AW:0] hp_q;

  assign base_o = hp_q[AW-1:0];
  assign room_o = room_for(int'(hp_q), SPRM_NEW, ALLOC_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) hp_q <= (AW+1)'(ALLOC_BASE);
    else if (take) hp_q <= hp_q + (AW+1)'(SPRM_NEW);
  end

  assert_take_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> room_o);

  assert_bump_by_three_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (hp_q == $past(hp_q) + (AW+1)'(SPRM_NEW)));

endmodule

// File: rtl/crw_args.sv
module crw_args #(
  parameter int AW = 8,
  parameter int NA = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue,
  input  logic [1:0]            idx,
  input  logic [AW-1:0]         rdata,
  output logic [NA-1:0][AW-1:0] args
);
  logic       pend_q;
  logic [1:0] pidx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pidx_q <= '0;
    end else begin
      pend_q <= issue;
      pidx_q <= idx;
    end
  end

  for (genvar g = 0; g < NA; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) args[g] <= '0;
      else if (pend_q && pidx_q == 2'(g)) args[g] <= rdata;
    end
  end

endmodule

// File: rtl/crw_seq.sv
module crw_seq #(
  parameter int AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [2:0]         op,
  output logic               ready,
  output logic [1:0]         spine_sel,
  input  logic [AW-1:0]      spine_node,
  output logic               spine_pop,
  output logic [1:0]         spine_pop_n,
  output logic               heap_re,
  output logic               heap_we,
  output logic [AW-1:0]      heap_node,
  output logic               heap_side,
  output logic [AW-1:0]      heap_wdata,
  input  logic [3:0][AW-1:0] args,
  input  logic [AW-1:0]      alloc_base,
  input  logic               alloc_room,
  output logic               alloc_take,
  output logic [1:0]         rd_idx,
  output logic               out_valid,
  output logic [AW-1:0]      out_ip,
  output logic               out_err,
  output logic               heap_full
);
  import crw_pkg::*;

  crw_state_e    st_q;
  logic [2:0]    op_q;
  logic          err_q;
  logic [1:0]    rd_q;
  logic [2:0]    wr_q;
  logic [AW-1:0] t0_q;
  logic          wrote_q;

  // One S' write step: {use_spine_root, node, side, data}
  function automatic logic [2*AW+1:0] sprm_step(
    input logic [2:0] k, input logic [AW-1:0] t0,
    input logic [3:0][AW-1:0] a);
    logic [AW-1:0] t1, t2;
    t1 = t0 + AW'(1);
    t2 = t0 + AW'(2);
    case (k)
      3'd0:    sprm_step = {1'b0, t0, SIDE_L, a[1]};
      3'd1:    sprm_step = {1'b0, t0, SIDE_R, a[3]};
      3'd2:    sprm_step = {1'b0, t1, SIDE_L, a[0]};
      3'd3:    sprm_step = {1'b0, t1, SIDE_R, t0};
      3'd4:    sprm_step = {1'b0, t2, SIDE_L, a[2]};
      3'd5:    sprm_step = {1'b0, t2, SIDE_R, a[3]};
      3'd6:    sprm_step = {1'b1, {AW{1'b0}}, SIDE_L, t1};
      default: sprm_step = {1'b1, {AW{1'b0}}, SIDE_R, t2};
    endcase
  endfunction

  logic [2*AW+1:0] step;
  logic            step_root;
  logic [AW-1:0]   step_node;
  logic            step_side;
  logic [AW-1:0]   step_data;
  logic            accept;
  logic            op_known;

  assign step = sprm_step(wr_q, t0_q, args);
  assign {step_root, step_node, step_side, step_data} = step;
  assign accept   = go && (st_q == ST_IDLE);
  assign op_known = (pops_for(op) != 2'd0);

  assign alloc_take = accept && (op == OP_SPRM) && alloc_room;
  assign rd_idx     = rd_q;
  assign ready      = (st_q == ST_IDLE);
  assign heap_full  = (st_q == ST_FULL);

  always_comb begin
    heap_re    = 1'b0;
    heap_we    = 1'b0;
    heap_node  = '0;
    heap_side  = SIDE_L;
    heap_wdata = '0;
    spine_sel  = 2'd0;
    case (st_q)
      ST_READ: begin
        spine_sel = rd_q;
        heap_re   = 1'b1;
        heap_node = spine_node;
        heap_side = SIDE_R;
      end
      ST_WRITE: begin
        spine_sel  = 2'd3;
        heap_we    = 1'b1;
        heap_node  = step_root ? spine_node : step_node;
        heap_side  = step_side;
        heap_wdata = step_data;
      end
      default: ;
    endcase
  end

  always_comb begin
    out_valid   = (st_q == ST_FIN);
    out_err     = out_valid && err_q;
    spine_pop   = out_valid && !err_q;
    spine_pop_n = spine_pop ? pops_for(op_q) : 2'd0;
    if (!out_valid || err_q) out_ip = '0;
    else if (op_q == OP_SPRM) out_ip = t0_q + AW'(1);
    else out_ip = args[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      err_q   <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
      t0_q    <= '0;
      wrote_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          wrote_q <= 1'b0;
          rd_q    <= '0;
          wr_q    <= '0;
          if (go) begin
            op_q <= op;
            if (!op_known) begin
              err_q <= 1'b1;
              st_q  <= ST_FIN;
            end else if (op == OP_SPRM && !alloc_room) begin
              st_q <= ST_FULL;
            end else begin
              if (op == OP_SPRM) t0_q <= alloc_base;
              st_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (rd_q == last_read(op_q)) st_q <= ST_WAIT;
          else rd_q <= rd_q + 2'd1;
        end
        ST_WAIT: st_q <= (op_q == OP_SPRM) ? ST_WRITE : ST_FIN;
        ST_WRITE: begin
          wrote_q <= 1'b1;
          if (wr_q == 3'(SPRM_WRITES - 1)) st_q <= ST_FIN;
          else wr_q <= wr_q + 3'd1;
        end
        ST_FIN: begin
          err_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_FULL;
      endcase
    end
  end

  assert_single_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(heap_re && heap_we));

  assert_reads_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    heap_re |-> !wrote_q);

  assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    heap_full |=> (heap_full && !heap_we && !out_valid && !ready));

  assert_err_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (!spine_pop && !wrote_q));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  assert_proj_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (heap_we |-> op_q == OP_SPRM));

endmodule

// File: rtl/crw_top.sv
module crw_top #(
  parameter int AW          = 8,
  parameter int ALLOC_BASE  = 16,
  parameter int ALLOC_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2:0]    op,
  output logic          ready,
  output logic [1:0]    spine_sel,
  input  logic [AW-1:0] spine_node,
  output logic          spine_pop,
  output logic [1:0]    spine_pop_n,
  output logic          heap_re,
  output logic          heap_we,
  output logic [AW-1:0] heap_node,
  output logic          heap_side,
  output logic [AW-1:0] heap_wdata,
  input  logic [AW-1:0] heap_rdata,
  output logic          out_valid,
  output logic [AW-1:0] out_ip,
  output logic          out_err,
  output logic          heap_full
);
  localparam int NARGS = crw_pkg::SPRM_READS;

  logic [NARGS-1:0][AW-1:0] args;
  logic [AW-1:0]            alloc_base;
  logic                     alloc_room;
  logic                     alloc_take;
  logic [1:0]               rd_idx;

  crw_alloc #(.AW(AW), .ALLOC_BASE(ALLOC_BASE), .ALLOC_LIMIT(ALLOC_LIMIT)) u_alloc (
    .clk(clk), .rst_n(rst_n), .take(alloc_take),
    .base_o(alloc_base), .room_o(alloc_room)
  );

  crw_args #(.AW(AW), .NA(NARGS)) u_args (
    .clk(clk), .rst_n(rst_n), .issue(heap_re), .idx(rd_idx),
    .rdata(heap_rdata), .args(args)
  );

  crw_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .ready(ready),
    .spine_sel(spine_sel), .spine_node(spine_node),
    .spine_pop(spine_pop), .spine_pop_n(spine_pop_n),
    .heap_re(heap_re), .heap_we(heap_we), .heap_node(heap_node),
    .heap_side(heap_side), .heap_wdata(heap_wdata),
    .args(args), .alloc_base(alloc_base), .alloc_room(alloc_room),
    .alloc_take(alloc_take), .rd_idx(rd_idx),
    .out_valid(out_valid), .out_ip(out_ip), .out_err(out_err),
    .heap_full(heap_full)
  );

endmodule

// File: tb/tb_crw_top.sv
module tb_crw_top;
  localparam int AW = 6;
  localparam int NN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [2:0] op = '0;
  logic ready, spine_pop, heap_re, heap_we, heap_side, out_valid, out_err, heap_full;
  logic [1:0] spine_sel, spine_pop_n;
  logic [AW-1:0] spine_node, heap_node, heap_wdata, heap_rdata, out_ip;

  always #2 clk = ~clk;

  crw_top #(.AW(AW), .ALLOC_BASE(32), .ALLOC_LIMIT(38)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .ready(ready),
    .spine_sel(spine_sel), .spine_node(spine_node),
    .spine_pop(spine_pop), .spine_pop_n(spine_pop_n),
    .heap_re(heap_re), .heap_we(heap_we), .heap_node(heap_node),
    .heap_side(heap_side), .heap_wdata(heap_wdata), .heap_rdata(heap_rdata),
    .out_valid(out_valid), .out_ip(out_ip), .out_err(out_err), .heap_full(heap_full)
  );

  // heap and spine models
  logic [AW-1:0] hl [NN];
  logic [AW-1:0] hr [NN];
  logic [AW-1:0] st [16];
  logic [3:0] sp = '0;
  int wr_count = 0;
  int late_reads = 0;
  bit wrote_in_op = 0;

  assign spine_node = st[sp + 4'(spine_sel)];

  always @(posedge clk) begin
    if (heap_re) begin
      heap_rdata <= heap_side ? hr[heap_node] : hl[heap_node];
      if (wrote_in_op) late_reads++;
    end
    if (heap_we) begin
      if (heap_side) hr[heap_node] <= heap_wdata;
      else hl[heap_node] <= heap_wdata;
      wr_count++;
      wrote_in_op = 1;
    end
    if (spine_pop) sp <= sp + 4'(spine_pop_n);
  end

  // scoreboard
  typedef struct { logic [AW-1:0] ip; logic err; int popn; string tag; } exp_t;
  exp_t expq[$];
  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R9/R11 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(out_ip == e.ip, {e.tag, " ip"}, int'(out_ip), int'(e.ip));
        chk(out_err == e.err, {e.tag, " err"}, int'(out_err), int'(e.err));
        chk((spine_pop ? int'(spine_pop_n) : 0) == e.popn, {e.tag, " pop"},
            spine_pop ? int'(spine_pop_n) : 0, e.popn);
      end
    end
  end

  task automatic run_op(input logic [2:0] code, input int ip, input bit err,
                        input int popn, input string tag);
    exp_t e;
    e.ip = AW'(ip); e.err = err; e.popn = popn; e.tag = tag;
    expq.push_back(e);
    wrote_in_op = 0;
    @(negedge clk); go = 1'b1; op = code;
    @(negedge clk); go = 1'b0;
    chk(ready == 1'b0, "R11 busy after accept", int'(ready), 0);
    while (!ready) @(negedge clk);
  endtask

  task automatic make_sprm(input int base, input int c, input int f, input int g, input int x);
    // spine nodes base..base+3, depth 0 on top
    hl[base] = 6'd1;     hr[base] = AW'(c);
    hl[base+1] = AW'(base);   hr[base+1] = AW'(f);
    hl[base+2] = AW'(base+1); hr[base+2] = AW'(g);
    hl[base+3] = AW'(base+2); hr[base+3] = AW'(x);
    for (int i = 0; i < 4; i++) st[i] = AW'(base + i);
    sp = '0;
  endtask

  initial begin
    int w0;
    for (int i = 0; i < NN; i++) begin hl[i] = '0; hr[i] = '0; end
    for (int i = 0; i < 16; i++) st[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R11 reset ready", int'(ready), 1);
    chk(heap_full == 1'b0, "R11 reset heap_full", int'(heap_full), 0);
    chk(out_valid == 1'b0, "R11 reset out_valid", int'(out_valid), 0);

    // R1: identity, two patterns
    hl[5] = 6'd1; hr[5] = 6'd9; st[0] = 6'd5; st[1] = 6'd7; sp = '0;
    w0 = wr_count;
    run_op(3'b001, 9, 0, 1, "R1 ident");
    chk(wr_count == w0, "R1 no heap write", wr_count - w0, 0);
    chk(sp == 4'd1, "R1 stack depth", int'(sp), 1);
    hr[7] = 6'd63; st[0] = 6'd7; sp = '0;
    run_op(3'b001, 63, 0, 1, "R1 ident top value");

    // R2: constant
    hl[6] = 6'd2; hr[6] = 6'd11; st[0] = 6'd6; st[1] = 6'd8; sp = '0;
    w0 = wr_count;
    run_op(3'b010, 11, 0, 2, "R2 const");
    chk(wr_count == w0, "R2 no heap write", wr_count - w0, 0);
    chk(sp == 4'd2, "R2 stack depth", int'(sp), 2);

    // S' first: c=20 f=21 g=22 x=23, temps 32..34
    make_sprm(1, 20, 21, 22, 23);
    w0 = wr_count;
    run_op(3'b100, 33, 0, 3, "R6 sprime ip");
    chk(hl[32] == 6'd21, "R4 temp0 left", int'(hl[32]), 21);
    chk(hr[32] == 6'd23, "R4 temp0 right", int'(hr[32]), 23);
    chk(hl[33] == 6'd20, "R4 temp1 left", int'(hl[33]), 20);
    chk(hr[33] == 6'd32, "R3 temp1 right is temp0", int'(hr[33]), 32);
    chk(hl[34] == 6'd22, "R4 temp2 left", int'(hl[34]), 22);
    chk(hr[34] == 6'd23, "R4 temp2 right", int'(hr[34]), 23);
    chk(hl[4] == 6'd33, "R5 root left", int'(hl[4]), 33);
    chk(hr[4] == 6'd34, "R5 root right", int'(hr[4]), 34);
    chk(hr[1] == 6'd20 && hl[1] == 6'd1, "R7 node d0 kept", int'(hr[1]), 20);
    chk(hr[2] == 6'd21 && hl[2] == 6'd1, "R7 node d1 kept", int'(hr[2]), 21);
    chk(hr[3] == 6'd22 && hl[3] == 6'd2, "R7 node d2 kept", int'(hr[3]), 22);
    chk(wr_count - w0 == 8, "R8 sprime write count", wr_count - w0, 8);
    chk(sp == 4'd3, "R6 stack depth", int'(sp), 3);

    // R10: unsupported codes
    st[0] = 6'd5; sp = '0;
    w0 = wr_count;
    run_op(3'b000, 0, 1, 0, "R10 code000");
    run_op(3'b111, 0, 1, 0, "R10 code111");
    chk(wr_count == w0, "R10 no heap write", wr_count - w0, 0);
    chk(sp == 4'd0, "R10 no pop", int'(sp), 0);

    // S' second: temps 35..37
    make_sprm(10, 40, 41, 42, 43);
    run_op(3'b100, 36, 0, 3, "R3 sprime second ip");
    chk(hl[35] == 6'd41 && hr[35] == 6'd43, "R3 temp0 at 35", int'(hl[35]), 41);
    chk(hr[36] == 6'd35, "R3 consecutive temps", int'(hr[36]), 35);
    chk(hl[13] == 6'd36 && hr[13] == 6'd37, "R5 root second", int'(hr[13]), 37);

    // R9: third S' overruns the limit of 38
    make_sprm(20, 1, 2, 3, 4);
    w0 = wr_count;
    @(negedge clk); go = 1'b1; op = 3'b100;
    @(negedge clk); go = 1'b0;
    repeat (20) @(negedge clk);
    chk(heap_full == 1'b1, "R9 heap_full", int'(heap_full), 1);
    chk(ready == 1'b0, "R9 ready low", int'(ready), 0);
    chk(wr_count == w0, "R9 no write", wr_count - w0, 0);
    chk(sp == 4'd0, "R9 no pop", int'(sp), 0);

    chk(late_reads == 0, "R8 read after write", late_reads, 0);
    chk(expq.size() == 0, "R11 all completions seen", expq.size(), 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule